// File: doc/BRIEF.md
# PCIe Application Reset Sequencer

This block creates the reset for user logic that runs next to a PCIe endpoint core. It collects the board-level fundamental reset and the lock flags of the two clock PLLs. It also takes the core's indication that it runs on the user clock, and three one-cycle, active-low link events from the core. From these it builds a single active-low application reset. That reset is asserted at once, released only in step with the user clock, and held for a minimum number of cycles after any trigger.

The core-ready output tells the core that the application clock is usable. A small cause field reports which condition started the current or most recent reset episode, so that firmware or a debug probe can tell a link event apart from a clock problem.

Top module: `pcie_app_rst_seq`

## Requirements
- R1: While `fund_rst_n` is low, `app_rst_n` and `core_ready` are low and `rst_cause` is 0. The assertion takes effect without waiting for a clock edge.
- R2: `app_rst_n` stays low for as long as `fixclk_lock` is low.
- R3: `app_rst_n` stays low for as long as `clk_inuse` is low.
- R4: `core_ready` equals `usrclk_lock` whenever `fund_rst_n` is high. A low `usrclk_lock` also holds `app_rst_n` low.
- R5: A low level on any of `dlx_n`, `hrx_n` or `l2x_n` at a rising edge drives `app_rst_n` low at that same edge. Each of these inputs is an active-low, single-cycle pulse.
- R6: If `fixclk_lock`, `usrclk_lock` or `clk_inuse` is low at a rising edge while `app_rst_n` is high, `app_rst_n` is low after that edge.
- R7: A trigger is any low lock or ready input, or any event pulse. `app_rst_n` rises at the (HOLD_CYCLES+2)-th rising edge after the last edge that saw a trigger, or after the release of `fund_rst_n`. A new trigger restarts this count.
- R8: `rst_cause` encodes the source as follows: 0 is the fundamental reset, 1 is a lock or ready loss, 2 is data-link-up exit, 3 is hot-reset exit and 4 is L2 exit. The field is written only by a trigger seen while `app_rst_n` is high. Triggers during an ongoing reset leave it unchanged.
- R9: When several sources trigger at the same edge, `rst_cause` takes the lowest code among them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| fund_rst_n | input | 1 | Fundamental reset, active low, asynchronous |
| fixclk_lock | input | 1 | Lock flag of the fixed transceiver-init clock PLL |
| usrclk_lock | input | 1 | Lock flag of the PLL producing the user clock |
| clk_inuse | input | 1 | Core reports it runs on the user clock |
| dlx_n | input | 1 | Data-link-up exit pulse, active low |
| hrx_n | input | 1 | Hot-reset exit pulse, active low |
| l2x_n | input | 1 | L2 exit pulse, active low |
| core_ready | output | 1 | Application clock ready, to the core |
| app_rst_n | output | 1 | Application reset, active low |
| rst_cause | output | 3 | Source of the latest reset episode |

## Verification
The bench places a second event in the middle of a hold window. A design that does not restart the counter would release too early, and one that rewrites the cause would report the later source. It applies simultaneous triggers, where a wrong priority shows up as the wrong cause code. It also counts the release edge exactly, so an off-by-one hold or a missing synchronizer stage is caught. Finally, it drops the fundamental reset halfway between edges, which exposes a design that asserts the reset only on a clock edge.

// File: rtl/pcie_app_rst_seq.sv
`timescale 1ns/1ps
module pcie_app_rst_seq #(
  parameter int HOLD_CYCLES = 16
) (
  input  logic       clk,
  input  logic       fund_rst_n,
  input  logic       fixclk_lock,
  input  logic       usrclk_lock,
  input  logic       clk_inuse,
  input  logic       dlx_n,
  input  logic       hrx_n,
  input  logic       l2x_n,
  output logic       core_ready,
  output logic       app_rst_n,
  output logic [2:0] rst_cause
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic          ok, ev, trig;
  logic [CW-1:0] cnt;
  logic          s1, s2;
  logic [2:0]    cause_q, cause_n;

  assign ok   = fixclk_lock & usrclk_lock & clk_inuse;
  assign ev   = ~(dlx_n & hrx_n & l2x_n);
  assign trig = ~ok | ev;

  always_comb begin
    if (!ok)          cause_n = 3'd1;
    else if (!dlx_n)  cause_n = 3'd2;
    else if (!hrx_n)  cause_n = 3'd3;
    else              cause_n = 3'd4;
  end

  always_ff @(posedge clk or negedge fund_rst_n) begin
    if (!fund_rst_n) begin
      cnt     <= CW'(HOLD_CYCLES);
      s1      <= 1'b0;
      s2      <= 1'b0;
      cause_q <= 3'd0;
    end else begin
      if (trig)          cnt <= CW'(HOLD_CYCLES);
      else if (cnt != 0) cnt <= cnt - CW'(1);
      s1 <= !trig && (cnt == 0);
      s2 <= !trig && s1;
      if (trig && s2) cause_q <= cause_n;
    end
  end

  assign app_rst_n  = s2;
  assign rst_cause  = cause_q;
  assign core_ready = usrclk_lock & fund_rst_n;

  p_rel_needs_lock_r2: assert property (@(posedge clk) disable iff (!fund_rst_n)
    app_rst_n |-> $past(fixclk_lock) && $past(clk_inuse));

  p_event_resets_r5: assert property (@(posedge clk) disable iff (!fund_rst_n)
    (!dlx_n || !hrx_n || !l2x_n) |=> !app_rst_n);

  p_drop_resets_r6: assert property (@(posedge clk) disable iff (!fund_rst_n)
    (app_rst_n && !ok) |=> !app_rst_n);

  p_min_hold_r7: assert property (@(posedge clk) disable iff (!fund_rst_n)
    $rose(app_rst_n) |-> $past(!trig) && $past(!trig, 2));

  p_cause_range_r8: assert property (@(posedge clk) disable iff (!fund_rst_n)
    rst_cause <= 3'd4);

  p_cause_held_r8: assert property (@(posedge clk) disable iff (!fund_rst_n)
    !$past(app_rst_n) |-> $stable(rst_cause));
endmodule

// File: tb/pcie_app_rst_seq_test.sv
`timescale 1ns/1ps
module pcie_app_rst_seq_test;
  localparam int H = 16;

  logic clk = 1'b0;
  logic fund_rst_n = 1'b0;
  logic fixclk_lock = 1'b1, usrclk_lock = 1'b1, clk_inuse = 1'b1;
  logic dlx_n = 1'b1, hrx_n = 1'b1, l2x_n = 1'b1;
  logic core_ready, app_rst_n;
  logic [2:0] rst_cause;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pcie_app_rst_seq #(.HOLD_CYCLES(H)) uut (
    .clk(clk), .fund_rst_n(fund_rst_n), .fixclk_lock(fixclk_lock),
    .usrclk_lock(usrclk_lock), .clk_inuse(clk_inuse), .dlx_n(dlx_n),
    .hrx_n(hrx_n), .l2x_n(l2x_n), .core_ready(core_ready),
    .app_rst_n(app_rst_n), .rst_cause(rst_cause));

  // mask bits: [8] fix drop [7] usr drop [6] inuse drop [5] dlx [4] hrx [3] l2x, [2:0] cause
  localparam logic [8:0] VEC [0:9] = '{
    9'b100000_001, 9'b010000_001, 9'b001000_001, 9'b000100_010, 9'b000010_011,
    9'b000001_100, 9'b000111_010, 9'b000011_011, 9'b100001_001, 9'b010110_001};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_release(input string req);
    repeat (H + 1) step();
    check(req, app_rst_n, 0);
    step();
    check(req, app_rst_n, 1);
  endtask

  initial begin
    repeat (3) step();
    check("R1 reset app", app_rst_n, 0);
    check("R1 reset ready", core_ready, 0);
    check("R1 reset cause", rst_cause, 0);
    fund_rst_n = 1'b1;
    #0.1 check("R4 ready follows lock", core_ready, 1);
    wait_release("R7 bring-up");

    // R2: fixed-clock lock low during bring-up
    fund_rst_n = 1'b0; fixclk_lock = 1'b0; step(); fund_rst_n = 1'b1;
    repeat (40) step();
    check("R2 held without fixed lock", app_rst_n, 0);
    fixclk_lock = 1'b1;
    wait_release("R2 release");
    check("R8 cause after fund reset", rst_cause, 0);

    // R3: clock-in-use low during bring-up
    fund_rst_n = 1'b0; clk_inuse = 1'b0; step(); fund_rst_n = 1'b1;
    repeat (40) step();
    check("R3 held without clk_inuse", app_rst_n, 0);
    clk_inuse = 1'b1;
    wait_release("R3 release");

    // vector table: one-cycle triggers from running state
    for (int i = 0; i < 10; i++) begin
      fixclk_lock = !VEC[i][8]; usrclk_lock = !VEC[i][7]; clk_inuse = !VEC[i][6];
      dlx_n = !VEC[i][5]; hrx_n = !VEC[i][4]; l2x_n = !VEC[i][3];
      #0.1 check("R4 core_ready", core_ready, !VEC[i][7]);
      step();
      check("R5/R6 reset asserted", app_rst_n, 0);
      check("R8/R9 cause", rst_cause, VEC[i][2:0]);
      fixclk_lock = 1'b1; usrclk_lock = 1'b1; clk_inuse = 1'b1;
      dlx_n = 1'b1; hrx_n = 1'b1; l2x_n = 1'b1;
      wait_release("R7 hold after trigger");
    end

    // R7 restart and R8 cause kept during hold
    dlx_n = 1'b0; step(); dlx_n = 1'b1;
    check("R5 dlx reset", app_rst_n, 0);
    repeat (8) step();
    l2x_n = 1'b0; step(); l2x_n = 1'b1;
    check("R8 cause kept during hold", rst_cause, 2);
    wait_release("R7 restart");

    // R6 sustained drop
    clk_inuse = 1'b0; step();
    check("R6 drop asserts", app_rst_n, 0);
    repeat (5) step();
    check("R6 stays low", app_rst_n, 0);
    clk_inuse = 1'b1;
    wait_release("R6 release");
    check("R8 cause lock loss", rst_cause, 1);

    // R1 asynchronous assertion between edges
    #1 fund_rst_n = 1'b0;
    #1 check("R1 async app", app_rst_n, 0);
    check("R1 async cause", rst_cause, 0);
    check("R1 async ready", core_ready, 0);
    step(); fund_rst_n = 1'b1;
    wait_release("R7 after async reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule